// File: doc/BRIEF.md
# Center-Spread Modulation Profile Controller

This block produces the digital frequency-offset waveform that steers a spread-spectrum clock synthesizer. It runs on the reference clock. While reset is asserted and for a short window after it, two shared pads act as strap inputs that choose one of four reference-frequency ranges. The block then latches that code and turns both pads into outputs that carry the modulated clocks. The latched range fixes how many reference cycles one modulation period lasts, so the modulation rate scales with the reference frequency.

The output is a signed 16-bit offset word in units of 1/65536 of the nominal frequency. It follows a symmetric triangle around zero: it starts at the positive peak, falls to the negative peak over half a period, then climbs back. A 2-bit spread select sets the peak. A one-cycle marker flags each pass through the maximum. When modulation is disabled, the word sits at zero. When it is re-enabled, the sweep resumes from the zero crossing on the falling ramp.

Top module: `sscg_profile_ctrl`

## Requirements
- R1: The range code is copied from `pad_i` on the first and second rising clock edges after `rst_n` deasserts, so the value at the second edge is kept. It is then held until the next reset. Bit 1 of the code is `pad_i[1]`. Codes 00, 01, 10 and 11 stand for references of 4–8, 8–16, 16–40 and 40–68 MHz.
- R2: `pad_oe` reads 00 while in reset and after the first edge. It reads 11 from the second edge onward and stays there until reset. While it is 11, `pad_o[0]` follows `clk1x_mod` and `pad_o[1]` follows `clk2x_mod`. While it is 00, `pad_o` is 00.
- R3: Any change on `pad_i` after the second edge leaves the latched range, and with it the period, unchanged.
- R4: The modulation period is 60, 120, 240 or 480 reference cycles for range codes 00, 01, 10 and 11.
- R5: The phase p counts 0 to DIV-1, with H = DIV/2 and s = 4 - range. For p ≤ H, t = 240 - (p<<s). Otherwise t = ((p-H)<<s) - 240. The offset is sign(t)·floor(|t|·M/256).
- R6: M is 350, 699, 1049 or 1398 for `spread_sel` 0, 1, 2 or 3 (1%, 2%, 3% or 4% total spread). The offset therefore reaches exactly +328/+655/+983/+1310 at p = 0 and the negative of that at p = H.
- R7: While modulation is inactive, `offset` is 0. It is also 0 at p = H/2 and at p = 3H/2. Each active cycle advances p by one. The first cycle that `mod_en` is seen high after the pads have turned, p takes the value H/2 + 1.
- R8: `period_start` is high for exactly one cycle, whenever the block is active and p = 0. It is never high otherwise.
- R9: While `spread_sel` stays constant and the block stays active, consecutive offsets differ by at most 88.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_i | input | 2 | Input value seen on the two shared pads (strap code) |
| clk1x_mod | input | 1 | Modulated 1X clock to be driven out on pad 0 |
| clk2x_mod | input | 1 | Modulated 2X clock to be driven out on pad 1 |
| mod_en | input | 1 | Enables the sweep; low forces zero offset |
| spread_sel | input | 2 | Total spread select, 1% to 4% |
| pad_o | output | 2 | Output value for the shared pads |
| pad_oe | output | 2 | Output enable for the shared pads |
| offset | output | 16 | Signed frequency offset, 1/65536 units |
| period_start | output | 1 | One-cycle pulse at each profile maximum |

## Verification
The assertions assume that `mod_en` and `spread_sel` are synchronous to `clk_ref`. They also assume the strap value stays stable on the pads until output enable rises. The step bound only holds while the spread select does not move, so that property is gated on a stable select. The stimulus changes every input a quarter period after a rising edge. It holds each strap code through the two sampling edges and flips the pads only afterwards. It also changes the spread select and toggles the enable mid-sweep, so that both the gated and ungated cases occur.

// File: rtl/sscg_pkg.sv
package sscg_pkg;
  localparam int FRAC_BITS = 8;

  typedef logic [1:0] range_t;

  // Fixed-point slope so that |t| = tri_amp maps to (sel+1) * 0.5 % of full scale.
  function automatic int spread_mult(input logic [1:0] sel, input int tri_amp, input int ofs_w);
    longint num;
    longint den;
    num = (longint'(sel) + 64'sd1) * (64'sd1 <<< ofs_w) * (64'sd1 <<< FRAC_BITS) * 64'sd5;
    den = longint'(tri_amp) * 64'sd1000;
    return int'((num + den / 64'sd2) / den);
  endfunction
endpackage

// File: rtl/sscg_strap_latch.sv
module sscg_strap_latch (
  input  logic            clk,
  input  logic            rst_n,
  input  sscg_pkg::range_t strap_i,
  output logic            run_o,
  output sscg_pkg::range_t range_o
);
  logic             sync_q;
  logic             run_q;
  sscg_pkg::range_t range_q;
  sscg_pkg::range_t range_d;

  // keep sampling until the pads are handed to the output drivers
  always_comb begin
    range_d = run_q ? range_q : strap_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      run_q   <= 1'b0;
      range_q <= 2'b11;
    end else begin
      sync_q  <= 1'b1;
      run_q   <= sync_q;
      range_q <= range_d;
    end
  end

  assign run_o   = run_q;
  assign range_o = range_q;
endmodule

// File: rtl/sscg_phase_gen.sv
module sscg_phase_gen #(
  parameter int BASE_DIV = 60,
  parameter int PH_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             en_i,
  input  sscg_pkg::range_t range_i,
  output logic [PH_W-1:0]  ph_o,
  output logic             act_o,
  output logic             pstart_o
);
  logic [PH_W-1:0] div_m1;
  logic [PH_W-1:0] qtr;
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;
  logic            act_d;
  logic            act_q;

  always_comb begin
    div_m1 = PH_W'((BASE_DIV << range_i) - 1);
    qtr    = PH_W'((BASE_DIV / 4) << range_i);
    act_d  = run_i & en_i;
    if (!act_d) begin
      ph_d = qtr;               // park on the falling zero crossing
    end else if (ph_q == div_m1) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      act_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      act_q <= act_d;
    end
  end

  assign ph_o     = ph_q;
  assign act_o    = act_q;
  assign pstart_o = act_q && (ph_q == '0);
endmodule

// File: rtl/sscg_tri_shaper.sv
module sscg_tri_shaper #(
  parameter int BASE_DIV = 60,
  parameter int PH_W     = 9,
  parameter int OFS_W    = 16
) (
  input  logic                    act_i,
  input  logic [PH_W-1:0]         ph_i,
  input  sscg_pkg::range_t        range_i,
  input  logic [1:0]              spread_i,
  output logic signed [OFS_W-1:0] offset_o
);
  localparam int TRI_AMP = (BASE_DIV / 2) << 3;

  int half;
  int sh;
  int tri_v;
  int tri_abs;
  int mult;
  int mag;

  always_comb begin
    half = (BASE_DIV / 2) << range_i;
    sh   = 4 - int'(range_i);
    if (int'(ph_i) <= half) begin
      tri_v = TRI_AMP - (int'(ph_i) << sh);
    end else begin
      tri_v = ((int'(ph_i) - half) << sh) - TRI_AMP;
    end
    tri_abs = (tri_v < 0) ? -tri_v : tri_v;
    mult    = sscg_pkg::spread_mult(spread_i, TRI_AMP, OFS_W);
    mag     = (tri_abs * mult) >>> sscg_pkg::FRAC_BITS;
    if (!act_i) begin
      offset_o = '0;
    end else begin
      offset_o = OFS_W'((tri_v < 0) ? -mag : mag);
    end
  end
endmodule

// File: rtl/sscg_profile_ctrl.sv
module sscg_profile_ctrl #(
  parameter int BASE_DIV = 60,
  parameter int OFS_W    = 16
) (
  input  logic                    clk_ref,
  input  logic                    rst_n,
  input  logic [1:0]              pad_i,
  input  logic                    clk1x_mod,
  input  logic                    clk2x_mod,
  input  logic                    mod_en,
  input  logic [1:0]              spread_sel,
  output logic [1:0]              pad_o,
  output logic [1:0]              pad_oe,
  output logic signed [OFS_W-1:0] offset,
  output logic                    period_start
);
  localparam int PH_W = $clog2(BASE_DIV << 3);

  logic             run;
  sscg_pkg::range_t range_lat;
  logic [PH_W-1:0]  phase;
  logic             active;

  sscg_strap_latch u_strap (
    .clk     (clk_ref),
    .rst_n   (rst_n),
    .strap_i (pad_i),
    .run_o   (run),
    .range_o (range_lat)
  );

  sscg_phase_gen #(.BASE_DIV(BASE_DIV), .PH_W(PH_W)) u_phase (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .run_i    (run),
    .en_i     (mod_en),
    .range_i  (range_lat),
    .ph_o     (phase),
    .act_o    (active),
    .pstart_o (period_start)
  );

  sscg_tri_shaper #(.BASE_DIV(BASE_DIV), .PH_W(PH_W), .OFS_W(OFS_W)) u_shape (
    .act_i    (active),
    .ph_i     (phase),
    .range_i  (range_lat),
    .spread_i (spread_sel),
    .offset_o (offset)
  );

  assign pad_oe = {2{run}};
  assign pad_o  = run ? {clk2x_mod, clk1x_mod} : 2'b00;
endmodule

// File: rtl/sscg_profile_chk.sv
module sscg_profile_chk #(
  parameter int BASE_DIV = 60,
  parameter int OFS_W    = 16
) (
  input logic                    clk_ref,
  input logic                    rst_n,
  input logic                    clk1x_mod,
  input logic                    clk2x_mod,
  input logic                    mod_en,
  input logic [1:0]              spread_sel,
  input logic [1:0]              pad_o,
  input logic [1:0]              pad_oe,
  input logic signed [OFS_W-1:0] offset,
  input logic                    period_start
);
  localparam int TRI_AMP = (BASE_DIV / 2) << 3;
  localparam int PK_MAX  = (TRI_AMP * sscg_pkg::spread_mult(2'd3, TRI_AMP, OFS_W)) >>> sscg_pkg::FRAC_BITS;

  logic signed [OFS_W-1:0] off_prev;
  int pk_now;
  int off_abs;
  int step_abs;

  always_ff @(posedge clk_ref) begin
    off_prev <= offset;
  end

  always_comb begin
    pk_now   = (TRI_AMP * sscg_pkg::spread_mult(spread_sel, TRI_AMP, OFS_W)) >>> sscg_pkg::FRAC_BITS;
    off_abs  = (offset < 0) ? -int'(offset) : int'(offset);
    step_abs = int'(offset) - int'(off_prev);
    if (step_abs < 0) step_abs = -step_abs;
  end

  p_oe_sticky_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pad_oe == 2'b11 |=> pad_oe == 2'b11);

  p_pad_route_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pad_oe == 2'b11 |-> pad_o == {clk2x_mod, clk1x_mod});

  p_pad_quiet_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
    pad_oe == 2'b00 |-> pad_o == 2'b00);

  p_peak_at_start_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    period_start |-> int'(offset) == pk_now);

  p_offset_bound_r6: assert property (@(posedge clk_ref) disable iff (!rst_n)
    off_abs <= PK_MAX);

  p_zero_idle_r7: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$past(mod_en) |-> offset == '0);

  p_single_pulse_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    period_start |=> !period_start);

  p_no_pulse_idle_r8: assert property (@(posedge clk_ref) disable iff (!rst_n)
    !$past(mod_en) |-> !period_start);

  p_small_step_r9: assert property (@(posedge clk_ref) disable iff (!rst_n)
    ($past(mod_en) && $past(mod_en, 2) && $past(pad_oe, 2) == 2'b11 && $stable(spread_sel))
      |-> step_abs <= 88);
endmodule

bind sscg_profile_ctrl sscg_profile_chk #(.BASE_DIV(BASE_DIV), .OFS_W(OFS_W)) u_chk (
  .clk_ref      (clk_ref),
  .rst_n        (rst_n),
  .clk1x_mod    (clk1x_mod),
  .clk2x_mod    (clk2x_mod),
  .mod_en       (mod_en),
  .spread_sel   (spread_sel),
  .pad_o        (pad_o),
  .pad_oe       (pad_oe),
  .offset       (offset),
  .period_start (period_start)
);

// File: tb/sscg_profile_ctrl_tb.sv
module sscg_profile_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic              clk_ref = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        pad_i = 2'b11;
  logic              clk1x_mod = 1'b0;
  logic              clk2x_mod = 1'b0;
  logic              mod_en = 1'b0;
  logic [1:0]        spread_sel = 2'd0;
  logic [1:0]        pad_o;
  logic [1:0]        pad_oe;
  logic signed [15:0] offset;
  logic              period_start;

  sscg_profile_ctrl u_dut (
    .clk_ref      (clk_ref),
    .rst_n        (rst_n),
    .pad_i        (pad_i),
    .clk1x_mod    (clk1x_mod),
    .clk2x_mod    (clk2x_mod),
    .mod_en       (mod_en),
    .spread_sel   (spread_sel),
    .pad_o        (pad_o),
    .pad_oe       (pad_oe),
    .offset       (offset),
    .period_start (period_start)
  );

  always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

  typedef struct { int ph; bit act; bit oe; } exp_t;
  exp_t q[$];

  int n_chk = 0;
  int n_fail = 0;
  int edges = 0;
  int mph = 0;
  bit mact = 1'b0;
  int latched = 3;
  int since_ps = -1;
  int prev_off = 0;
  bit prev_act = 1'b0;
  logic [1:0] prev_spread = 2'd0;
  bit done = 1'b0;

  // expected offset from the R5 / R6 formula
  function automatic int model_off(input int ph, input int rng, input int spr);
    int half, sh, t, m, a, mag;
    half = 30 << rng;
    sh   = 4 - rng;
    if (ph <= half) t = 240 - (ph << sh);
    else            t = ((ph - half) << sh) - 240;
    case (spr)
      0: m = 350;
      1: m = 699;
      2: m = 1049;
      default: m = 1398;
    endcase
    a   = (t < 0) ? -t : t;
    mag = (a * m) >>> 8;
    return (t < 0) ? -mag : mag;
  endfunction

  task automatic check(input string tag, input logic signed [31:0] act, input logic signed [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver side of the scoreboard: reference model pushes one item per edge
  always @(posedge clk_ref) begin
    exp_t e;
    if (!rst_n) begin
      edges = 0;
      mact  = 1'b0;
      mph   = 0;
    end else begin
      mact = (edges >= 2) && mod_en;
      if (!mact)                          mph = 15 << latched;
      else if (mph == (60 << latched) - 1) mph = 0;
      else                                mph = mph + 1;
      edges++;
    end
    e.ph  = mph;
    e.act = mact;
    e.oe  = (edges >= 2);
    q.push_back(e);
  end

  // monitor side: pop and compare away from the active edge
  always @(negedge clk_ref) begin
    if (q.size() > 0) begin
      exp_t e;
      int eo, half, qtr;
      string tag;
      logic [1:0] ep;
      e = q.pop_front();
      if (!rst_n) begin
        check("R2 reset pad_oe", 32'(pad_oe), 0);
        check("R7 reset offset", 32'(offset), 0);
        check("R8 reset period_start", 32'(period_start), 0);
        since_ps = -1;
        prev_act = 1'b0;
      end else begin
        half = 30 << latched;
        qtr  = 15 << latched;
        eo   = e.act ? model_off(e.ph, latched, int'(spread_sel)) : 0;
        if (!e.act)                                  tag = "R7 idle zero";
        else if (e.ph == 0 || e.ph == half)          tag = "R6 turning point";
        else if (e.ph == qtr || e.ph == qtr + half)  tag = "R7 midpoint zero";
        else                                         tag = "R5 ramp";
        check(tag, 32'(offset), eo);
        check("R8 period_start", 32'(period_start), (e.act && e.ph == 0) ? 1 : 0);
        check("R2 pad_oe", 32'(pad_oe), e.oe ? 3 : 0);
        ep = e.oe ? {clk2x_mod, clk1x_mod} : 2'b00;
        check("R2 pad_o", 32'(pad_o), 32'(ep));
        if (e.act && prev_act && spread_sel == prev_spread) begin
          int d;
          d = int'(offset) - prev_off;
          if (d < 0) d = -d;
          check("R9 step bound", (d <= 88) ? 1 : 0, 1);
        end
        if (!e.act) begin
          since_ps = -1;
        end else begin
          if (since_ps >= 0) since_ps++;
          if (period_start) begin
            if (since_ps > 0) check("R1/R3/R4 period", since_ps, 60 << latched);
            since_ps = 0;
          end
        end
        prev_act = e.act;
      end
      prev_off    = int'(offset);
      prev_spread = spread_sel;
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_ref);
      #(CLK_PERIOD / 4);
      clk2x_mod = ~clk2x_mod;
      if (clk2x_mod) clk1x_mod = ~clk1x_mod;
    end
  endtask

  task automatic do_reset(input logic [1:0] strap);
    rst_n  = 1'b0;
    mod_en = 1'b0;
    pad_i  = strap;
    tick(4);
    rst_n   = 1'b1;
    latched = int'(strap);
    tick(3);
    pad_i = ~strap;   // R3: pads flipped after the sampling window
  endtask

  initial begin
    tick(2);
    for (int r = 0; r < 4; r++) begin
      do_reset(2'(r));
      tick(3);
      mod_en     = 1'b1;
      spread_sel = 2'(r);
      tick(2 * (60 << r) + 7);
      pad_i      = ~pad_i;
      spread_sel = 2'((r + 1) % 4);
      tick(60 << r);
      mod_en = 1'b0;
      tick(5);
      mod_en = 1'b1;
      tick(2 * (60 << r) + 3);
    end
    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule